// File: doc/BRIEF.md
# Transmit Descriptor Status Bank

This block holds the status words of four transmit descriptors in a 10/100 Ethernet controller. Each word has four groups of fields. The driver writes three of them: a 13-bit byte count, an ownership flag and a 6-bit early-start threshold code. The transmit side sets the completion flags: transmit ok, underrun, abort, carrier lost, out-of-window collision and heartbeat failure. It also loads a 4-bit collision count. When the host writes a descriptor, all of that descriptor's completion status is wiped, so the next completion report starts from zero.

The host bus writes full 32-bit words through plain strobes and reads a descriptor through a combinational read port. A transmit engine reports completion as per-descriptor pulses. A DMA done pulse hands ownership back to the driver. An end-of-transmission pulse opens a heartbeat window, and a heartbeat pulse inside that window closes it. The block also gives a start-transmit decision for the descriptor now selected. That decision compares the FIFO fill level with the descriptor's threshold and takes the complete-packet flag into account. It is held back while the previous descriptor is long and still owned by the driver.

The block has no streaming data path. Every interface is a single-cycle strobe or a level, so no port has back-pressure. Writes are always taken in the cycle they are presented.

Top module: `txd_status_bank`

## Requirements
- R1: Descriptor n is read and written at byte offset 4·n. Words at offsets whose two low bits are not 00 read as 0 and take no writes. A read returns the whole word in this layout: bit 31 carrier lost, 30 abort, 29 out-of-window collision, 28 heartbeat fail, 27:24 collision count, 23:22 zero, 21:16 threshold code, 15 transmit ok, 14 underrun, 13 ownership, 12:0 byte count.
- R2: After reset each word reads 0x00002000, with only the ownership bit set.
- R3: A full write loads the threshold, ownership and byte count from the written data. Bits 31:22, 15 and 14 of the write data have no effect.
- R4: A write whose byte enables are not all 1 leaves the word unchanged.
- R5: An accepted write clears bits 31:24, 15 and 14 of that descriptor.
- R6: A completion pulse sets abort, carrier-lost and out-of-window flags and the underrun flag from its inputs, and loads the collision count. It sets transmit ok only when ok is given without underrun.
- R7: A DMA done pulse sets the ownership bit of its descriptor.
- R8: In 10 Mbps mode, heartbeat fail is set on the descriptor of the last end-of-transmission when HB_CYCLES cycles pass without a heartbeat pulse. A heartbeat pulse inside the window prevents this.
- R9: While the 100 Mbps mode input is high, the heartbeat-fail bit reads 0 and the window never opens.
- R10: start_tx is high when the FIFO level is at least the threshold. Threshold code 0 means 8 bytes, and code k from 1 to 63 means 32·k bytes.
- R11: start_tx is high when the FIFO holds a complete packet, whatever the level.
- R12: start_tx is low while the previous descriptor (cur_idx−1, wrapping) has a byte count above 1792 and ownership 0.
- R13: When a write and a completion or DMA pulse hit the same descriptor in one cycle, the written values win and status is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write byte address |
| wr_be | input | 4 | Host write byte enables |
| wr_data | input | 32 | Host write data |
| rd_addr | input | ADDR_W | Host read byte address |
| rd_data | output | 32 | Read word (combinational) |
| ev_valid | input | 1 | Completion pulse |
| ev_idx | input | IDX_W | Descriptor of the completion |
| ev_ok | input | 1 | Packet completed |
| ev_unr | input | 1 | FIFO ran empty during the packet |
| ev_abort | input | 1 | Transmission aborted |
| ev_crs | input | 1 | Carrier lost |
| ev_owc | input | 1 | Out-of-window collision |
| ev_ncc | input | 4 | Collision count |
| dma_done | input | 1 | DMA completion pulse |
| dma_idx | input | IDX_W | Descriptor of the DMA completion |
| tx_end | input | 1 | End of transmission, opens heartbeat window |
| tx_idx | input | IDX_W | Descriptor that ended |
| hb_seen | input | 1 | Collision heartbeat observed |
| speed_100 | input | 1 | 100 Mbps mode |
| cur_idx | input | IDX_W | Descriptor being considered for start |
| fifo_level | input | FIFO_W | Bytes in the transmit FIFO |
| fifo_has_pkt | input | 1 | FIFO holds a complete packet |
| start_tx | output | 1 | Start-transmit decision |

## Verification
Two functions can fall in the same cycle: the host write that clears status and a completion or DMA pulse for the same descriptor. The bench provokes this by driving a full write, an abort completion and a DMA done to descriptor 0 on one clock edge. It then checks that the read word holds exactly the written fields, with no abort, collision count or ownership set by the pulses. The heartbeat expiry and a speed switch also meet on one descriptor. The bench lets a failure latch and then raises the 100 Mbps input, and it expects the bit to read back as 0.

// File: rtl/txd_pkg.sv
package txd_pkg;

  typedef struct packed {
    logic        crs;
    logic        abort;
    logic        owc;
    logic        cdh;
    logic [3:0]  ncc;
    logic [5:0]  thr;
    logic        ok;
    logic        unr;
    logic        own;
    logic [12:0] size;
  } txd_word_t;

  typedef struct packed {
    logic       ok;
    logic       unr;
    logic       abort;
    logic       crs;
    logic       owc;
    logic [3:0] ncc;
  } txd_evt_t;

  localparam txd_word_t TXD_RST = '{own: 1'b1, default: '0};

  function automatic logic [31:0] txd_pack(txd_word_t w);
    return {w.crs, w.abort, w.owc, w.cdh, w.ncc, 2'b00, w.thr,
            w.ok, w.unr, w.own, w.size};
  endfunction

endpackage

// File: rtl/txd_word.sv
module txd_word
  import txd_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_hit,
  input  logic [5:0]  wr_thr,
  input  logic        wr_own,
  input  logic [12:0] wr_size,
  input  logic        ev_hit,
  input  txd_evt_t    ev,
  input  logic        dma_hit,
  input  logic        hb_hit,
  input  logic        speed_100,
  output txd_word_t   w
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w <= TXD_RST;
    end else if (wr_hit) begin
      w.thr   <= wr_thr;
      w.own   <= wr_own;
      w.size  <= wr_size;
      w.crs   <= 1'b0;
      w.abort <= 1'b0;
      w.owc   <= 1'b0;
      w.cdh   <= 1'b0;
      w.ncc   <= '0;
      w.ok    <= 1'b0;
      w.unr   <= 1'b0;
    end else begin
      if (ev_hit) begin
        w.crs   <= w.crs   | ev.crs;
        w.abort <= w.abort | ev.abort;
        w.owc   <= w.owc   | ev.owc;
        w.unr   <= w.unr   | ev.unr;
        w.ok    <= w.ok    | (ev.ok & ~ev.unr);
        w.ncc   <= ev.ncc;
      end
      if (dma_hit) w.own <= 1'b1;
      if (speed_100)   w.cdh <= 1'b0;
      else if (hb_hit) w.cdh <= 1'b1;
    end
  end

  a_r5_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (!w.crs && !w.abort && !w.owc && !w.cdh && w.ncc == 4'd0 && !w.ok && !w.unr));

  a_r3_fields_loaded: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> (w.thr == $past(wr_thr) && w.own == $past(wr_own) && w.size == $past(wr_size)));

  a_r7_dma_sets_own: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_hit && !wr_hit) |=> w.own);

  a_r9_no_hb_at_100: assert property (@(posedge clk) disable iff (!rst_n)
    speed_100 |=> !w.cdh);

endmodule

// File: rtl/txd_hb_timer.sv
module txd_hb_timer #(
  parameter int HB_CYCLES = 640,
  parameter int IDX_W     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_end,
  input  logic [IDX_W-1:0] tx_idx,
  input  logic             hb_seen,
  input  logic             speed_100,
  output logic             fail,
  output logic [IDX_W-1:0] fail_idx
);

  localparam int CNT_W = (HB_CYCLES > 2) ? $clog2(HB_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HB_CYCLES - 1);

  logic             armed;
  logic [CNT_W-1:0] cnt;

  assign fail = armed && !hb_seen && !speed_100 && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      cnt      <= '0;
      fail_idx <= '0;
    end else if (speed_100) begin
      armed <= 1'b0;
    end else if (tx_end) begin
      armed    <= 1'b1;
      cnt      <= '0;
      fail_idx <= tx_idx;
    end else if (armed) begin
      if (hb_seen || cnt == LAST) armed <= 1'b0;
      else                        cnt   <= cnt + 1'b1;
    end
  end

  a_r8_single_fail: assert property (@(posedge clk) disable iff (!rst_n)
    fail |=> !fail);

  a_r9_no_fail_100: assert property (@(posedge clk) disable iff (!rst_n)
    $past(speed_100) |-> !fail);

endmodule

// File: rtl/txd_start_gate.sv
module txd_start_gate #(
  parameter int FIFO_W     = 12,
  parameter int LONG_LIMIT = 1792
) (
  input  logic [5:0]        thr_code,
  input  logic [12:0]       prev_size,
  input  logic              prev_own,
  input  logic [FIFO_W-1:0] fifo_level,
  input  logic              fifo_has_pkt,
  output logic              start_tx
);

  localparam logic [12:0] LONG_SZ = 13'(LONG_LIMIT);

  logic [FIFO_W-1:0] thr_bytes;
  logic              held;

  always_comb begin
    if (thr_code == 6'd0) thr_bytes = FIFO_W'(8);
    else                  thr_bytes = FIFO_W'({thr_code, 5'b00000});
    held     = (prev_size > LONG_SZ) && !prev_own;
    start_tx = !held && (fifo_has_pkt || (fifo_level >= thr_bytes));
  end

endmodule

// File: rtl/txd_status_bank.sv
module txd_status_bank
  import txd_pkg::*;
#(
  parameter int NDESC      = 4,
  parameter int HB_CYCLES  = 640,
  parameter int LONG_LIMIT = 1792,
  parameter int FIFO_W     = 12,
  localparam int IDX_W     = $clog2(NDESC),
  localparam int ADDR_W    = IDX_W + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [3:0]        wr_be,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  input  logic              ev_valid,
  input  logic [IDX_W-1:0]  ev_idx,
  input  logic              ev_ok,
  input  logic              ev_unr,
  input  logic              ev_abort,
  input  logic              ev_crs,
  input  logic              ev_owc,
  input  logic [3:0]        ev_ncc,
  input  logic              dma_done,
  input  logic [IDX_W-1:0]  dma_idx,
  input  logic              tx_end,
  input  logic [IDX_W-1:0]  tx_idx,
  input  logic              hb_seen,
  input  logic              speed_100,
  input  logic [IDX_W-1:0]  cur_idx,
  input  logic [FIFO_W-1:0] fifo_level,
  input  logic              fifo_has_pkt,
  output logic              start_tx
);

  txd_word_t [NDESC-1:0] words;
  txd_evt_t              evt;
  logic                  wr_ok;
  logic                  hb_fail;
  logic [IDX_W-1:0]      hb_idx;
  logic [IDX_W-1:0]      prev_idx;
  logic                  unused_wr;

  assign evt       = '{ok: ev_ok, unr: ev_unr, abort: ev_abort, crs: ev_crs,
                       owc: ev_owc, ncc: ev_ncc};
  assign wr_ok     = wr_en && (wr_be == 4'hF) && (wr_addr[1:0] == 2'b00);
  assign unused_wr = ^{wr_data[31:22], wr_data[15:14]};

  txd_hb_timer #(.HB_CYCLES(HB_CYCLES), .IDX_W(IDX_W)) u_hb (
    .clk(clk), .rst_n(rst_n), .tx_end(tx_end), .tx_idx(tx_idx),
    .hb_seen(hb_seen), .speed_100(speed_100),
    .fail(hb_fail), .fail_idx(hb_idx)
  );

  for (genvar d = 0; d < NDESC; d++) begin : g_desc
    txd_word u_word (
      .clk(clk), .rst_n(rst_n),
      .wr_hit(wr_ok && (wr_addr[ADDR_W-1:2] == IDX_W'(d))),
      .wr_thr(wr_data[21:16]), .wr_own(wr_data[13]), .wr_size(wr_data[12:0]),
      .ev_hit(ev_valid && (ev_idx == IDX_W'(d))), .ev(evt),
      .dma_hit(dma_done && (dma_idx == IDX_W'(d))),
      .hb_hit(hb_fail && (hb_idx == IDX_W'(d))),
      .speed_100(speed_100),
      .w(words[d])
    );
  end

  assign rd_data  = (rd_addr[1:0] == 2'b00) ? txd_pack(words[rd_addr[ADDR_W-1:2]]) : 32'h0;
  assign prev_idx = cur_idx - 1'b1;

  txd_start_gate #(.FIFO_W(FIFO_W), .LONG_LIMIT(LONG_LIMIT)) u_gate (
    .thr_code(words[cur_idx].thr),
    .prev_size(words[prev_idx].size), .prev_own(words[prev_idx].own),
    .fifo_level(fifo_level), .fifo_has_pkt(fifo_has_pkt),
    .start_tx(start_tx)
  );

  a_r4_partial_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be != 4'hF && !ev_valid && !dma_done && !hb_fail && !speed_100)
      |=> $stable(words));

endmodule

// File: tb/test_txd_status_bank.sv
module test_txd_status_bank;

  localparam int CLK_PERIOD = 10;
  localparam int HB = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 0;
  logic [3:0]  wr_addr = 0;
  logic [3:0]  wr_be = 0;
  logic [31:0] wr_data = 0;
  logic [3:0]  rd_addr = 0;
  logic [31:0] rd_data;
  logic        ev_valid = 0;
  logic [1:0]  ev_idx = 0;
  logic        ev_ok = 0, ev_unr = 0, ev_abort = 0, ev_crs = 0, ev_owc = 0;
  logic [3:0]  ev_ncc = 0;
  logic        dma_done = 0;
  logic [1:0]  dma_idx = 0;
  logic        tx_end = 0;
  logic [1:0]  tx_idx = 0;
  logic        hb_seen = 0;
  logic        speed_100 = 0;
  logic [1:0]  cur_idx = 0;
  logic [11:0] fifo_level = 0;
  logic        fifo_has_pkt = 0;
  logic        start_tx;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  typedef struct {
    logic [1:0]  idx;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  txd_status_bank #(.HB_CYCLES(HB)) i_txd_status_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_be(wr_be),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .ev_valid(ev_valid), .ev_idx(ev_idx), .ev_ok(ev_ok), .ev_unr(ev_unr),
    .ev_abort(ev_abort), .ev_crs(ev_crs), .ev_owc(ev_owc), .ev_ncc(ev_ncc),
    .dma_done(dma_done), .dma_idx(dma_idx), .tx_end(tx_end), .tx_idx(tx_idx),
    .hb_seen(hb_seen), .speed_100(speed_100), .cur_idx(cur_idx),
    .fifo_level(fifo_level), .fifo_has_pkt(fifo_has_pkt), .start_tx(start_tx)
  );

  // monitor: pops expected words and compares the read port
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      rd_addr = {it.idx, 2'b00};
      #1;
      checks++;
      if (rd_data !== it.exp) begin
        errors++;
        $display("FAIL %s desc%0d actual %h expected %h", it.tag, it.idx, rd_data, it.exp);
      end
    end
  end

  task automatic expect_word(input logic [1:0] idx, input logic [31:0] exp, input string tag);
    q.push_back('{idx: idx, exp: exp, tag: tag});
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [3:0] addr, input logic [3:0] be, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1; wr_addr = addr; wr_be = be; wr_data = data;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic complete(input logic [1:0] idx, input logic ok, input logic unr,
                          input logic ab, input logic crs, input logic owc, input logic [3:0] ncc);
    @(negedge clk);
    ev_valid = 1; ev_idx = idx; ev_ok = ok; ev_unr = unr;
    ev_abort = ab; ev_crs = crs; ev_owc = owc; ev_ncc = ncc;
    @(negedge clk);
    ev_valid = 0;
  endtask

  task automatic dma(input logic [1:0] idx);
    @(negedge clk);
    dma_done = 1; dma_idx = idx;
    @(negedge clk);
    dma_done = 0;
  endtask

  task automatic end_tx(input logic [1:0] idx);
    @(negedge clk);
    tx_end = 1; tx_idx = idx;
    @(negedge clk);
    tx_end = 0;
  endtask

  task automatic gate(input logic [11:0] lvl, input logic pkt, input logic exp, input string tag);
    @(negedge clk);
    fifo_level = lvl; fifo_has_pkt = pkt;
    #1;
    chk(start_tx, exp, tag);
  endtask

  task automatic summary;
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2 reset values
    for (int d = 0; d < 4; d++) expect_word(2'(d), 32'h0000_2000, "R2 reset");
    // R3 all-ones write, only writable fields land
    host_wr(4'h4, 4'hF, 32'hFFFF_FFFF);
    expect_word(2'd1, 32'h003F_3FFF, "R3 writable fields");
    // R4 partial enables ignored
    host_wr(4'h4, 4'h7, 32'h0);
    expect_word(2'd1, 32'h003F_3FFF, "R4 partial write");
    // R1 misaligned write ignored, misaligned read returns zero
    host_wr(4'h5, 4'hF, 32'h0);
    expect_word(2'd1, 32'h003F_3FFF, "R1 misaligned write");
    @(negedge clk); wait (q.size() == 0);
    rd_addr = 4'h6; #1; checks++;
    if (rd_data !== 32'h0) begin errors++; $display("FAIL R1 misaligned read actual %h expected 0", rd_data); end
    // R6 completion with all error flags
    host_wr(4'h8, 4'hF, 32'h0000_0100);
    expect_word(2'd2, 32'h0000_0100, "R1 layout after write");
    complete(2'd2, 1, 0, 1, 1, 1, 4'd3);
    expect_word(2'd2, 32'hE300_8100, "R6 completion flags");
    // R5 write clears status
    host_wr(4'h8, 4'hF, 32'h0000_0100);
    expect_word(2'd2, 32'h0000_0100, "R5 clear on write");
    // R6 ok suppressed by underrun
    complete(2'd2, 1, 1, 0, 0, 0, 4'd0);
    expect_word(2'd2, 32'h0000_4100, "R6 underrun no ok");
    // R7 DMA done
    dma(2'd2);
    expect_word(2'd2, 32'h0000_6100, "R7 ownership set");
    // R8 heartbeat missing
    end_tx(2'd3);
    repeat (HB + 3) @(negedge clk);
    expect_word(2'd3, 32'h1000_2000, "R8 heartbeat missing");
    host_wr(4'hC, 4'hF, 32'h0);
    end_tx(2'd3);
    repeat (3) @(negedge clk);
    hb_seen = 1; @(negedge clk); hb_seen = 0;
    repeat (HB + 3) @(negedge clk);
    expect_word(2'd3, 32'h0000_0000, "R8 heartbeat in window");
    // R9 switch to 100M clears a latched failure
    end_tx(2'd0);
    repeat (HB + 3) @(negedge clk);
    expect_word(2'd0, 32'h1000_2000, "R8 heartbeat missing desc0");
    speed_100 = 1;
    @(negedge clk);
    expect_word(2'd0, 32'h0000_2000, "R9 cleared at 100M");
    end_tx(2'd0);
    repeat (HB + 3) @(negedge clk);
    expect_word(2'd0, 32'h0000_2000, "R9 no window at 100M");
    speed_100 = 0;
    // R13 write with completion and DMA done in the same cycle
    @(negedge clk);
    wr_en = 1; wr_addr = 4'h0; wr_be = 4'hF; wr_data = 32'h0000_0040;
    ev_valid = 1; ev_idx = 2'd0; ev_ok = 0; ev_unr = 0; ev_abort = 1;
    ev_crs = 0; ev_owc = 0; ev_ncc = 4'd5;
    dma_done = 1; dma_idx = 2'd0;
    @(negedge clk);
    wr_en = 0; ev_valid = 0; dma_done = 0;
    expect_word(2'd0, 32'h0000_0040, "R13 write wins");
    // R10 thresholds on descriptor 1
    cur_idx = 2'd1;
    host_wr(4'h4, 4'hF, 32'h0000_0010);
    gate(12'd7, 0, 0, "R10 code0 below 8");
    gate(12'd8, 0, 1, "R10 code0 at 8");
    host_wr(4'h4, 4'hF, 32'h0002_0010);
    gate(12'd63, 0, 0, "R10 code2 below 64");
    gate(12'd64, 0, 1, "R10 code2 at 64");
    // R11 complete packet
    gate(12'd0, 1, 1, "R11 complete packet");
    // R12 long previous descriptor
    host_wr(4'h0, 4'hF, 32'h0000_0701);
    gate(12'd64, 1, 0, "R12 long prev held");
    host_wr(4'h0, 4'hF, 32'h0000_0700);
    gate(12'd64, 0, 1, "R12 exactly 1792 not held");
    host_wr(4'h0, 4'hF, 32'h0000_0701);
    dma(2'd0);
    gate(12'd64, 0, 1, "R12 released by ownership");
    repeat (2) @(negedge clk);
    summary();
  end

endmodule